// File: doc/BRIEF.md
# Data Translation Fault Entry Sequencer

This block sits beside the data-side address translation lookup of a processor core. Each time the lookup finishes, it reports whether a translation entry matched and what access rights that entry grants. The sequencer decides whether the access faults, either because no entry matched (a translation miss) or because the matching entry forbids the access (a protection fault). On a fault it saves the processor context into a bank of fault-context registers, switches the status word to privileged mode with further exceptions blocked, and redirects instruction fetch to the fault handler.

All context registers load at the clock edge that closes the strobe cycle. The redirect pulse and the handler address appear in the following cycle, alongside the saved values. While the block bit of the incoming status word is set, or while a redirect is still being presented, new strobes are dropped. They are not queued.

Top module: `mfe_fault_entry`

## Requirements
- R1: A cycle with `chk_valid`=1 raises a fault when `tlb_hit`=0 (miss) or when `tlb_hit`=1 and the rights in `tlb_pr` forbid the access (protection). Privilege is `sr_in[30]`. `tlb_pr[1]`=1 grants user-mode access. `tlb_pr[0]`=1 grants write access. Privileged mode ignores `tlb_pr[1]`. A permitted hit changes nothing.
- R2: `access_op` encodes 0 load, 1 store, 2 cache purge, 3 cache write-back, 4 cache invalidate, 5 allocating store. Codes 0, 2 and 3 count as reads. Codes 1, 4 and 5 count as writes. Codes 6 and 7 count as reads.
- R3: `evt_code` becomes 0x0A0 for a protection fault on a read, 0x0C0 for a protection fault on a write, 0x040 for a miss on a read, and 0x060 for a miss on a write.
- R4: `tr_vpn` receives `fault_vaddr[31:10]`, and `fault_addr` receives the whole of `fault_vaddr`.
- R5: `saved_pc` receives `cur_pc`, or `branch_pc` when `in_delay_slot`=1.
- R6: `saved_sr` receives `sr_in`, and `saved_gr` receives `r15_in`.
- R7: `sr_out` receives `sr_in` with bit 30 (mode) and bit 28 (block) forced to 1. All other bits are unchanged.
- R8: `redirect_valid` is a one-cycle pulse in the cycle after an accepted strobe. In that cycle `redirect_pc` equals the `vbr_in` of the strobe cycle plus 0x400.
- R9: A strobe is ignored when `sr_in[28]`=1 or when `redirect_valid`=1. Ignored means that no output changes and no fault is queued for later.
- R10: While `rst_n`=0, every output register is zero and `redirect_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | Lookup result strobe |
| tlb_hit | input | 1 | A translation entry matched |
| tlb_pr | input | 2 | Rights of the matching entry (bit1 user, bit0 write) |
| access_op | input | 3 | Access kind, see R2 |
| fault_vaddr | input | 32 | Virtual address of the access |
| cur_pc | input | 32 | PC of the accessing instruction |
| in_delay_slot | input | 1 | Instruction sits in a delay slot |
| branch_pc | input | 32 | PC of the delayed branch |
| sr_in | input | 32 | Current status word |
| r15_in | input | 32 | Current general register 15 |
| vbr_in | input | 32 | Vector base |
| tr_vpn | output | 22 | Saved virtual page number |
| fault_addr | output | 32 | Saved faulting address |
| evt_code | output | 12 | Exception event code |
| saved_pc | output | 32 | Saved PC |
| saved_sr | output | 32 | Saved status word |
| saved_gr | output | 32 | Saved register 15 |
| sr_out | output | 32 | Status word for handler entry |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Handler fetch address |

## Verification
Directed cases cover every access kind under a miss and under each rights value, in both user and privileged mode, so that a wrong read/write classification or a wrong rights decode shows up as a wrong code. Delay-slot strobes use a branch PC that differs from the current PC, which separates the two save sources. Back-to-back strobes and strobes with the block bit set show whether anything is queued or overwritten. A random stream then mixes all of these against a behavioural model compared every cycle.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_PURGE = 3'd2,
    OP_WBACK = 3'd3,
    OP_INVAL = 3'd4,
    OP_ALLOC = 3'd5
  } acc_op_e;

  typedef enum logic {
    FK_MISS = 1'b0,
    FK_PROT = 1'b1
  } fault_kind_e;

  localparam int CODE_W = 12;
  localparam logic [CODE_W-1:0] CODE_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] CODE_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] CODE_PROT_RD = 12'h0A0;
  localparam logic [CODE_W-1:0] CODE_PROT_WR = 12'h0C0;

  // Cache-maintenance kinds fold onto read or write here.
  function automatic logic op_is_write(input logic [2:0] op);
    logic w;
    case (op)
      OP_STORE, OP_INVAL, OP_ALLOC: w = 1'b1;
      default:                      w = 1'b0;
    endcase
    return w;
  endfunction

  // Rights check: bit1 opens user mode, bit0 opens writes.
  function automatic logic rights_allow(input logic [1:0] pr,
                                        input logic wr,
                                        input logic priv);
    return (priv | pr[1]) & (~wr | pr[0]);
  endfunction

  function automatic logic [CODE_W-1:0] calc_event_code(input fault_kind_e k,
                                                        input logic wr);
    logic [CODE_W-1:0] c;
    if (k == FK_PROT) c = wr ? CODE_PROT_WR : CODE_PROT_RD;
    else              c = wr ? CODE_MISS_WR : CODE_MISS_RD;
    return c;
  endfunction
endpackage

// File: rtl/mfe_classify.sv
module mfe_classify
  import mfe_pkg::*;
(
  input  logic       chk_valid,
  input  logic       tlb_hit,
  input  logic [1:0] tlb_pr,
  input  logic [2:0] access_op,
  input  logic       priv,
  output logic       fault_raise,
  output logic       fault_kind,
  output logic       fault_wr
);
  logic is_wr;
  logic allowed;

  always_comb begin
    is_wr       = op_is_write(access_op);
    allowed     = rights_allow(tlb_pr, is_wr, priv);
    fault_wr    = is_wr;
    fault_kind  = tlb_hit ? FK_PROT : FK_MISS;
    fault_raise = chk_valid & (~tlb_hit | ~allowed);
  end
endmodule

// File: rtl/mfe_context.sv
module mfe_context
  import mfe_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int DW         = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int MD_BIT     = 30,
  parameter int BL_BIT     = 28,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              kind,
  input  logic              wr,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [DW-1:0]     cur_pc,
  input  logic              in_ds,
  input  logic [DW-1:0]     br_pc,
  input  logic [DW-1:0]     sr_in,
  input  logic [DW-1:0]     r15_in,
  output logic [VPN_W-1:0]  vpn_q,
  output logic [VA_W-1:0]   tea_q,
  output logic [CODE_W-1:0] code_q,
  output logic [DW-1:0]     spc_q,
  output logic [DW-1:0]     ssr_q,
  output logic [DW-1:0]     sgr_q,
  output logic [DW-1:0]     sr_q
);
  logic [DW-1:0]     sr_entry;
  logic [DW-1:0]     pc_pick;
  logic [CODE_W-1:0] code_next;

  for (genvar i = 0; i < DW; i++) begin : g_sr_bit
    if (i == MD_BIT || i == BL_BIT) begin : g_force
      assign sr_entry[i] = 1'b1;
    end else begin : g_keep
      assign sr_entry[i] = sr_in[i];
    end
  end

  assign pc_pick   = in_ds ? br_pc : cur_pc;
  assign code_next = calc_event_code(fault_kind_e'(kind), wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      tea_q  <= '0;
      code_q <= '0;
      spc_q  <= '0;
      ssr_q  <= '0;
      sgr_q  <= '0;
      sr_q   <= '0;
    end else if (take) begin
      vpn_q  <= vaddr[VA_W-1:PAGE_SHIFT];
      tea_q  <= vaddr;
      code_q <= code_next;
      spc_q  <= pc_pick;
      ssr_q  <= sr_in;
      sgr_q  <= r15_in;
      sr_q   <= sr_entry;
    end
  end
endmodule

// File: rtl/mfe_redirect.sv
module mfe_redirect #(
  parameter int          DW         = 32,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] vbr_in,
  output logic          redir_v,
  output logic [DW-1:0] redir_pc
);
  function automatic logic [DW-1:0] vector_of(input logic [DW-1:0] base);
    return base + DW'(VEC_OFFSET);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_v  <= 1'b0;
      redir_pc <= '0;
    end else begin
      redir_v <= take;
      if (take) redir_pc <= vector_of(vbr_in);
    end
  end
endmodule

// File: rtl/mfe_fault_entry.sv
module mfe_fault_entry
  import mfe_pkg::*;
#(
  parameter int          VA_W       = 32,
  parameter int          DW         = 32,
  parameter int          PAGE_SHIFT = 10,
  parameter int          MD_BIT     = 30,
  parameter int          BL_BIT     = 28,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0400,
  localparam int         VPN_W      = VA_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic              tlb_hit,
  input  logic [1:0]        tlb_pr,
  input  logic [2:0]        access_op,
  input  logic [VA_W-1:0]   fault_vaddr,
  input  logic [DW-1:0]     cur_pc,
  input  logic              in_delay_slot,
  input  logic [DW-1:0]     branch_pc,
  input  logic [DW-1:0]     sr_in,
  input  logic [DW-1:0]     r15_in,
  input  logic [DW-1:0]     vbr_in,
  output logic [VPN_W-1:0]  tr_vpn,
  output logic [VA_W-1:0]   fault_addr,
  output logic [CODE_W-1:0] evt_code,
  output logic [DW-1:0]     saved_pc,
  output logic [DW-1:0]     saved_sr,
  output logic [DW-1:0]     saved_gr,
  output logic [DW-1:0]     sr_out,
  output logic              redirect_valid,
  output logic [DW-1:0]     redirect_pc
);
  // Named internal events, visible to the bound checker.
  logic fault_raise_w;
  logic fault_kind_w;
  logic fault_wr_w;
  logic blocked_w;
  logic accept_w;

  mfe_classify u_cls (
    .chk_valid   (chk_valid),
    .tlb_hit     (tlb_hit),
    .tlb_pr      (tlb_pr),
    .access_op   (access_op),
    .priv        (sr_in[MD_BIT]),
    .fault_raise (fault_raise_w),
    .fault_kind  (fault_kind_w),
    .fault_wr    (fault_wr_w)
  );

  assign blocked_w = sr_in[BL_BIT] | redirect_valid;
  assign accept_w  = fault_raise_w & ~blocked_w;

  mfe_context #(
    .VA_W(VA_W), .DW(DW), .PAGE_SHIFT(PAGE_SHIFT),
    .MD_BIT(MD_BIT), .BL_BIT(BL_BIT)
  ) u_ctx (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (accept_w),
    .kind   (fault_kind_w),
    .wr     (fault_wr_w),
    .vaddr  (fault_vaddr),
    .cur_pc (cur_pc),
    .in_ds  (in_delay_slot),
    .br_pc  (branch_pc),
    .sr_in  (sr_in),
    .r15_in (r15_in),
    .vpn_q  (tr_vpn),
    .tea_q  (fault_addr),
    .code_q (evt_code),
    .spc_q  (saved_pc),
    .ssr_q  (saved_sr),
    .sgr_q  (saved_gr),
    .sr_q   (sr_out)
  );

  mfe_redirect #(.DW(DW), .VEC_OFFSET(VEC_OFFSET)) u_rdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept_w),
    .vbr_in   (vbr_in),
    .redir_v  (redirect_valid),
    .redir_pc (redirect_pc)
  );
endmodule

// File: rtl/mfe_checker.sv
module mfe_checker #(
  parameter int          VA_W       = 32,
  parameter int          DW         = 32,
  parameter int          MD_BIT     = 30,
  parameter int          BL_BIT     = 28,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0400
) (
  input logic            clk,
  input logic            rst_n,
  input logic            chk_valid,
  input logic            tlb_hit,
  input logic            in_delay_slot,
  input logic [DW-1:0]   branch_pc,
  input logic [DW-1:0]   sr_in,
  input logic [DW-1:0]   r15_in,
  input logic [DW-1:0]   vbr_in,
  input logic [VA_W-1:0] fault_addr,
  input logic [11:0]     evt_code,
  input logic [DW-1:0]   saved_pc,
  input logic [DW-1:0]   saved_sr,
  input logic [DW-1:0]   saved_gr,
  input logic [DW-1:0]   sr_out,
  input logic            redirect_valid,
  input logic [DW-1:0]   redirect_pc,
  input logic            fault_raise_w,
  input logic            fault_kind_w,
  input logic            fault_wr_w,
  input logic            accept_w
);
  p_miss_raises_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !tlb_hit) |-> fault_raise_w);

  p_prot_read_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && fault_kind_w && !fault_wr_w) |=> (evt_code == 12'h0A0));

  p_prot_write_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && fault_kind_w && fault_wr_w) |=> (evt_code == 12'h0C0));

  p_branch_pc_saved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && in_delay_slot) |=> (saved_pc == $past(branch_pc)));

  p_context_saved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (saved_sr == $past(sr_in) && saved_gr == $past(r15_in)));

  p_priv_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (sr_out[MD_BIT] && sr_out[BL_BIT]));

  p_redirect_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (redirect_valid && redirect_pc == $past(vbr_in) + DW'(VEC_OFFSET)));

  p_redirect_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  p_blocked_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && sr_in[BL_BIT]) |=> ($stable(fault_addr) && !redirect_valid));
endmodule

bind mfe_fault_entry mfe_checker #(
  .VA_W(VA_W), .DW(DW), .MD_BIT(MD_BIT), .BL_BIT(BL_BIT), .VEC_OFFSET(VEC_OFFSET)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .chk_valid      (chk_valid),
  .tlb_hit        (tlb_hit),
  .in_delay_slot  (in_delay_slot),
  .branch_pc      (branch_pc),
  .sr_in          (sr_in),
  .r15_in         (r15_in),
  .vbr_in         (vbr_in),
  .fault_addr     (fault_addr),
  .evt_code       (evt_code),
  .saved_pc       (saved_pc),
  .saved_sr       (saved_sr),
  .saved_gr       (saved_gr),
  .sr_out         (sr_out),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .fault_raise_w  (fault_raise_w),
  .fault_kind_w   (fault_kind_w),
  .fault_wr_w     (fault_wr_w),
  .accept_w       (accept_w)
);

// File: tb/sim_mfe_fault_entry.sv
`timescale 1ns/1ps
module sim_mfe_fault_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic        tlb_hit = 1'b0;
  logic [1:0]  tlb_pr = '0;
  logic [2:0]  access_op = '0;
  logic [31:0] fault_vaddr = '0, cur_pc = '0, branch_pc = '0;
  logic        in_delay_slot = 1'b0;
  logic [31:0] sr_in = '0, r15_in = '0, vbr_in = '0;
  logic [21:0] tr_vpn;
  logic [31:0] fault_addr, saved_pc, saved_sr, saved_gr, sr_out, redirect_pc;
  logic [11:0] evt_code;
  logic        redirect_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mfe_fault_entry u0 (.*);

  // Behavioural reference model
  logic [21:0] m_vpn;
  logic [31:0] m_tea, m_spc, m_ssr, m_sgr, m_sr, m_rpc;
  logic [11:0] m_code;
  bit          m_rv;
  bit          m_taken [$];

  function automatic bit m_is_write(input int op);
    return (op == 1) || (op == 4) || (op == 5);
  endfunction

  function automatic bit m_allowed(input int pr, input bit wr, input bit priv);
    bit user_ok, write_ok;
    user_ok  = (pr >= 2);
    write_ok = (pr == 1) || (pr == 3);
    return (priv || user_ok) && (!wr || write_ok);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vpn = 0; m_tea = 0; m_code = 0; m_spc = 0; m_ssr = 0;
      m_sgr = 0; m_sr = 0; m_rv = 0; m_rpc = 0;
    end else begin
      bit wr, flt, acc;
      wr  = m_is_write(int'(access_op));
      flt = chk_valid && (!tlb_hit || !m_allowed(int'(tlb_pr), wr, sr_in[30]));
      acc = flt && !sr_in[28] && !m_rv;
      if (acc) begin
        m_vpn  = fault_vaddr >> 10;
        m_tea  = fault_vaddr;
        if (tlb_hit) m_code = wr ? 12'd192 : 12'd160;
        else         m_code = wr ? 12'd96  : 12'd64;
        m_spc  = in_delay_slot ? branch_pc : cur_pc;
        m_ssr  = sr_in;
        m_sgr  = r15_in;
        m_sr   = sr_in | 32'h5000_0000;
        m_rpc  = vbr_in + 32'd1024;
        m_taken.push_back(1'b1);
      end
      m_rv = acc;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R4", "tr_vpn", 32'(tr_vpn), 32'(m_vpn));
    chk("R4", "fault_addr", fault_addr, m_tea);
    chk("R1/R2/R3", "evt_code", 32'(evt_code), 32'(m_code));
    chk("R5", "saved_pc", saved_pc, m_spc);
    chk("R6", "saved_sr", saved_sr, m_ssr);
    chk("R6", "saved_gr", saved_gr, m_sgr);
    chk("R7", "sr_out", sr_out, m_sr);
    chk("R8/R9", "redirect_valid", 32'(redirect_valid), 32'(m_rv));
    if (m_rv) chk("R8", "redirect_pc", redirect_pc, m_rpc);
  endtask

  task automatic step(input bit v, input bit hit, input int pr, input int op,
                      input logic [31:0] va, input logic [31:0] pc,
                      input bit ds, input logic [31:0] bpc,
                      input logic [31:0] sr, input logic [31:0] r15,
                      input logic [31:0] vbr);
    @(negedge clk);
    compare_all();
    chk_valid = v; tlb_hit = hit; tlb_pr = pr[1:0]; access_op = op[2:0];
    fault_vaddr = va; cur_pc = pc; in_delay_slot = ds; branch_pc = bpc;
    sr_in = sr; r15_in = r15; vbr_in = vbr;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 32'h0, 32'h0, 0, 32'h0, 32'h0, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs are zero during reset
    chk("R10", "redirect_valid", 32'(redirect_valid), 32'h0);
    chk("R10", "sr_out", sr_out, 32'h0);
    chk("R10", "evt_code", 32'(evt_code), 32'h0);
    rst_n = 1'b1;
    idle();
    // R1/R2/R3: every access kind, miss and each rights value, user and privileged
    for (int op = 0; op < 8; op++) begin
      for (int pr = 0; pr < 5; pr++) begin
        for (int md = 0; md < 2; md++) begin
          step(1, pr < 4, pr % 4, op, 32'h8000_0000 + (op << 16) + (pr << 12) + 32'h3F7,
               32'h0C00_1000 + (op << 4), 0, 32'hDEAD_0000,
               (md ? 32'h4000_00F0 : 32'h0000_00F0), 32'h1234_0000 + op, 32'h8C00_0000);
          idle();
        end
      end
    end
    // R5: delay slot saves the branch PC
    step(1, 0, 0, 1, 32'h1234_5678, 32'h0000_2002, 1, 32'h0000_2000, 32'h1, 32'h77, 32'hA000_0000);
    idle();
    // R9: block bit set -> ignored, nothing queued
    step(1, 0, 0, 0, 32'hFFFF_FC00, 32'h3000, 0, 32'h0, 32'h1000_0000, 32'h55, 32'hB000_0000);
    idle(); idle();
    // R9: back-to-back faults, second is dropped while redirect is presented
    step(1, 0, 0, 0, 32'h0000_0400, 32'h4000, 0, 32'h0, 32'h0, 32'h1, 32'h0000_1000);
    step(1, 1, 0, 1, 32'h0000_0800, 32'h5000, 0, 32'h0, 32'h0, 32'h2, 32'h0000_2000);
    idle(); idle();
    // R8: vector base wraps around
    step(1, 0, 0, 4, 32'h0, 32'h6000, 0, 32'h0, 32'h0, 32'h3, 32'hFFFF_FE00);
    idle();
    // Mixed random stream
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] s;
      s = $urandom;
      step(s[0], s[1], int'(s[3:2]), int'(s[6:4]), $urandom, $urandom, s[7], $urandom,
           {1'b0, s[8], 1'b0, (s[11:9] == 3'b000), 28'(s[31:12])}, $urandom, $urandom);
    end
    idle(); idle();
    checks++;
    if (m_taken.size() < 20) begin
      errors++;
      $display("FAIL R9 accepted fault count: actual %0d expected >= 20", m_taken.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule